// File: doc/BRIEF.md
# Circular command ring fetcher

This block drains a circular queue of 32-bit command words that software builds in memory. Software writes the start and end of the ring, then appends words and moves the write pointer forward. While the read pointer trails the write pointer, the block reads one DWORD at a time from a simple memory-request port. It hands each word to a downstream command parser over a valid/ready handshake. The read pointer moves only when the parser takes a word.

The pointers hold 24-bit byte offsets. The upper 12 address bits come from a separate configuration input, so the whole ring sits inside one 16 MB window. The read pointer returns to the start of the ring in two cases. The first is when the word at the last ring location is consumed. The second is when the parser flags that the word it is taking ends a command whose wrap flag was set, so software can close a lap early.

The sequencer has four states:
- `FS_IDLE`: the ring is empty or the next fetch has not started.
- `FS_REQ`: a read request is presented.
- `FS_WAIT`: the request was granted and the data is awaited.
- `FS_HOLD`: the word is offered downstream.

Its transitions are:
- IDLE→REQ when the pointers differ.
- REQ→WAIT on grant.
- WAIT→HOLD on read data valid.
- HOLD→IDLE on handshake.

Top module: `cmd_ring_fetcher`

## Requirements
- R1: After reset the four pointers read back as zero, and `busy`, `mem_req` and `cmd_valid` are low.
- R2: A write through `reg_we` stores `reg_wdata` into the pointer chosen by `reg_sel` (0 = ring start, 1 = ring end, which is the last DWORD of the ring, 2 = read pointer, 3 = write pointer). `reg_rdata` returns the pointer chosen by `reg_raddr` with the same encoding, with bits [1:0] always zero, so bits [1:0] of a write are ignored.
- R3: A write to the read pointer loads the same aligned value into the write pointer, which leaves the ring empty with `busy` low.
- R4: While the read and write pointers are equal, no request is issued. `busy` is high when they differ or a fetch is in flight. Each request carries the address `{cfg_base, read pointer}`.
- R5: At most one memory read is outstanding. `mem_req` stays high with a stable address until `mem_gnt`, and no new request is made while a fetched word waits downstream.
- R6: `cmd_valid` stays high with stable `cmd_data` until `cmd_ready`. The read pointer changes only on a handshake, and it then advances by 4 unless a wrap applies.
- R7: A handshake of the word at the ring end offset sets the read pointer to the ring start.
- R8: `wrap_req` high during a handshake sets the read pointer to the ring start, whatever its position. `wrap_req` without a handshake has no effect.
- R9: The words delivered downstream are the memory contents at successive read-pointer positions, in ring order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 12 | Upper address bits of the ring window |
| reg_we | input | 1 | Pointer register write strobe |
| reg_sel | input | 2 | Pointer selected for writing |
| reg_wdata | input | 24 | Pointer write value (byte offset) |
| reg_raddr | input | 2 | Pointer selected for read-back |
| reg_rdata | output | 24 | Read-back value of the selected pointer |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 36 | Memory read byte address |
| mem_gnt | input | 1 | Request accepted by memory |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Command word offered to the parser |
| cmd_data | output | 32 | Command word |
| cmd_ready | input | 1 | Parser accepts the word |
| wrap_req | input | 1 | Word being accepted ends a command with the wrap flag set |
| busy | output | 1 | Ring not empty or fetch in flight |

## Verification
The checks assume the following about software:
- It rewrites the ring start, ring end and read pointer only while `busy` is low.
- It never writes a register in a cycle where a wrap lands.
- Memory returns exactly one `mem_rvalid` per grant.

The random producer in the bench keeps to these rules. It only moves the write pointer forward or back to the ring start, and it never lets the write pointer overtake unconsumed words. It places an early wrap only behind a word that is still queued. The memory model grants and answers one request at a time with random latency, and start, end and read-pointer writes happen only after the ring has drained.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2,
        FS_HOLD = 2'd3
    } fetch_state_e;

    typedef enum logic [1:0] {
        PSEL_TOP = 2'd0,
        PSEL_BOT = 2'd1,
        PSEL_RD  = 2'd2,
        PSEL_WR  = 2'd3
    } ptr_sel_e;

endpackage

// File: rtl/ring_ptr_regs.sv
module ring_ptr_regs
    import cmd_ring_pkg::*;
#(
    parameter int OFS_W   = 24,
    parameter int ALIGN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [OFS_W-1:0] wr_val,
    input  logic             adv,
    input  logic             wrap,
    output logic [OFS_W-1:0] top_q,
    output logic [OFS_W-1:0] bot_q,
    output logic [OFS_W-1:0] rd_q,
    output logic [OFS_W-1:0] wr_q
);
    localparam int STEP = 1 << ALIGN_W;

    logic [OFS_W-1:0] val_al;
    logic [OFS_W-1:0] rd_next;

    assign val_al = {wr_val[OFS_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

    // early wrap from the parser or natural wrap at the ring end
    always_comb begin
        if (wrap || (rd_q == bot_q)) rd_next = top_q;
        else                         rd_next = rd_q + OFS_W'(STEP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
            bot_q <= '0;
            rd_q  <= '0;
            wr_q  <= '0;
        end else begin
            if (wr_en && (wr_sel == PSEL_TOP)) top_q <= val_al;
            if (wr_en && (wr_sel == PSEL_BOT)) bot_q <= val_al;
            if (wr_en && (wr_sel == PSEL_RD)) begin
                rd_q <= val_al;
                wr_q <= val_al;
            end else begin
                if (adv)                           rd_q <= rd_next;
                if (wr_en && (wr_sel == PSEL_WR))  wr_q <= val_al;
            end
        end
    end

endmodule

// File: rtl/ring_fetch_fsm.sv
module ring_fetch_fsm
    import cmd_ring_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pending,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    input  logic          cmd_ready,
    output logic          mem_req,
    output logic          cmd_valid,
    output logic [DW-1:0] cmd_data,
    output logic          accept,
    output logic          active
);
    fetch_state_e st_q, st_d;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_IDLE: if (pending)    st_d = FS_REQ;
            FS_REQ:  if (mem_gnt)    st_d = FS_WAIT;
            FS_WAIT: if (mem_rvalid) st_d = FS_HOLD;
            FS_HOLD: if (cmd_ready)  st_d = FS_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        cmd_valid = 1'b0;
        active    = 1'b1;
        unique case (st_q)
            FS_IDLE: active    = 1'b0;
            FS_REQ:  mem_req   = 1'b1;
            FS_WAIT: ;
            FS_HOLD: cmd_valid = 1'b1;
        endcase
        accept = cmd_valid && cmd_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            data_q <= '0;
        else if (st_q == FS_WAIT && mem_rvalid) data_q <= mem_rdata;
    end

    assign cmd_data = data_q;

endmodule

// File: rtl/cmd_ring_fetcher.sv
module cmd_ring_fetcher
    import cmd_ring_pkg::*;
#(
    parameter int BASE_W = 12,
    parameter int OFS_W  = 24,
    parameter int DW     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BASE_W-1:0]       cfg_base,
    input  logic                    reg_we,
    input  logic [1:0]              reg_sel,
    input  logic [OFS_W-1:0]        reg_wdata,
    input  logic [1:0]              reg_raddr,
    output logic [OFS_W-1:0]        reg_rdata,
    output logic                    mem_req,
    output logic [BASE_W+OFS_W-1:0] mem_addr,
    input  logic                    mem_gnt,
    input  logic                    mem_rvalid,
    input  logic [DW-1:0]           mem_rdata,
    output logic                    cmd_valid,
    output logic [DW-1:0]           cmd_data,
    input  logic                    cmd_ready,
    input  logic                    wrap_req,
    output logic                    busy
);
    localparam int ADDR_W = BASE_W + OFS_W;

    logic [OFS_W-1:0] top_ofs, bot_ofs, rd_ofs, wr_ofs;
    logic             accept, active, pending;

    assign pending = (rd_ofs != wr_ofs);

    ring_ptr_regs #(.OFS_W(OFS_W), .ALIGN_W(2)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_we),
        .wr_sel (reg_sel),
        .wr_val (reg_wdata),
        .adv    (accept),
        .wrap   (wrap_req),
        .top_q  (top_ofs),
        .bot_q  (bot_ofs),
        .rd_q   (rd_ofs),
        .wr_q   (wr_ofs)
    );

    ring_fetch_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .cmd_ready  (cmd_ready),
        .mem_req    (mem_req),
        .cmd_valid  (cmd_valid),
        .cmd_data   (cmd_data),
        .accept     (accept),
        .active     (active)
    );

    assign mem_addr = ADDR_W'({cfg_base, rd_ofs});
    assign busy     = pending || active;

    always_comb begin
        unique case (reg_raddr)
            PSEL_TOP: reg_rdata = top_ofs;
            PSEL_BOT: reg_rdata = bot_ofs;
            PSEL_RD:  reg_rdata = rd_ofs;
            PSEL_WR:  reg_rdata = wr_ofs;
        endcase
    end

endmodule

// File: rtl/ring_fetch_chk.sv
module ring_fetch_chk #(
    parameter int OFS_W = 24,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [1:0]       reg_sel,
    input logic             mem_req,
    input logic             mem_gnt,
    input logic [35:0]      mem_addr,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [DW-1:0]    cmd_data,
    input logic             wrap_req,
    input logic             busy,
    input logic [OFS_W-1:0] top_ofs,
    input logic [OFS_W-1:0] bot_ofs,
    input logic [OFS_W-1:0] rd_ofs,
    input logic [OFS_W-1:0] wr_ofs
);
    logic hs;
    assign hs = cmd_valid && cmd_ready;

    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ofs[1:0] == 2'b00) && (wr_ofs[1:0] == 2'b00) && (top_ofs[1:0] == 2'b00) && (bot_ofs[1:0] == 2'b00)); // R2

    AST_RD_LOADS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd2) |=> (wr_ofs == rd_ofs)); // R3

    AST_BUSY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ofs != wr_ofs) |-> busy); // R4

    AST_NO_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> (rd_ofs != wr_ofs)); // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R5

    AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !mem_req); // R5

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data))); // R6

    AST_RD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs && !reg_we) |=> $stable(rd_ofs)); // R6

    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !wrap_req && rd_ofs != bot_ofs && !reg_we) |=> (rd_ofs == $past(rd_ofs) + OFS_W'(4))); // R6

    AST_NAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && rd_ofs == bot_ofs && !reg_we) |=> (rd_ofs == $past(top_ofs))); // R7

    AST_EARLY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && wrap_req && !reg_we) |=> (rd_ofs == $past(top_ofs))); // R8

endmodule

bind cmd_ring_fetcher ring_fetch_chk #(.OFS_W(OFS_W), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_addr  (36'(mem_addr)),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .wrap_req  (wrap_req),
    .busy      (busy),
    .top_ofs   (top_ofs),
    .bot_ofs   (bot_ofs),
    .rd_ofs    (rd_ofs),
    .wr_ofs    (wr_ofs)
);

// File: tb/tb_cmd_ring_fetcher.sv
module tb_cmd_ring_fetcher;
    localparam logic [11:0] BASE = 12'hA5C;
    localparam logic [23:0] TOP  = 24'h000100;
    localparam logic [23:0] BOT  = 24'h00013C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_base = BASE;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [23:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = 2'd0;
    logic [23:0] reg_rdata;
    logic        mem_req;
    logic [35:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        cmd_valid;
    logic [31:0] cmd_data;
    logic        cmd_ready = 1'b0;
    logic        wrap_req = 1'b0;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cmd_ring_fetcher dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .wrap_req(wrap_req), .busy(busy)
    );

    function automatic logic [31:0] word_of(input logic [23:0] ofs);
        return {8'hC3, ofs} ^ {ofs[11:0], 20'h5A3F1};
    endfunction

    function automatic logic [23:0] ring_next(input logic [23:0] p);
        return (p == BOT) ? TOP : p + 24'd4;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bench model state
    logic [23:0] model_rd = TOP;
    logic [23:0] sw_wr = TOP;
    logic [23:0] mark_a = '0;
    bit          mark_v = 0;
    int          lat = 0;
    logic [23:0] lat_ofs = '0;
    logic [1:0]  last_sel = 2'd2;
    int          n_nat = 0;
    int          n_early = 0;
    int          n_stray = 0;

    task automatic step(input bit en_prod, input bit en_cons);
        logic [23:0] nxt;
        @(negedge clk);
        reg_we = 1'b0;
        // read-back of read/write pointer (R2, R6)
        if (last_sel == 2'd2) chk(reg_rdata == model_rd, "R6", 36'(reg_rdata), 36'(model_rd));
        else                  chk(reg_rdata == sw_wr,    "R2", 36'(reg_rdata), 36'(sw_wr));
        // memory model
        mem_gnt = 1'b0;
        mem_rvalid = 1'b0;
        if (lat > 0) begin
            lat--;
            if (lat == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata = word_of(lat_ofs);
            end
        end else if (mem_req && ($urandom % 3 != 0)) begin
            chk(mem_addr == {BASE, model_rd}, "R4", mem_addr, {BASE, model_rd});
            mem_gnt = 1'b1;
            lat_ofs = mem_addr[23:0];
            lat = 1 + ($urandom % 3);
        end
        // consumer
        cmd_ready = en_cons && ($urandom % 4 != 0);
        wrap_req = 1'b0;
        if (cmd_valid && cmd_ready) begin
            chk(cmd_data == word_of(model_rd), "R9", 36'(cmd_data), 36'(word_of(model_rd)));
            if (mark_v && model_rd == mark_a) begin
                wrap_req = 1'b1;
                mark_v = 0;
                if (model_rd != BOT) n_early++;
                model_rd = TOP;
            end else if (model_rd == BOT) begin
                n_nat++;
                model_rd = TOP;
            end else begin
                model_rd = model_rd + 24'd4;
            end
        end else if ($urandom % 8 == 0) begin
            wrap_req = 1'b1;   // stray, must be ignored (R8)
            n_stray++;
        end
        // producer
        if (en_prod && ($urandom % 3 == 0)) begin
            nxt = ring_next(sw_wr);
            if (!mark_v && ($urandom % 6 == 0) && sw_wr != TOP && sw_wr != model_rd && model_rd != TOP) begin
                mark_a = sw_wr - 24'd4;
                mark_v = 1;
                sw_wr = TOP;
                reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = TOP | 24'($urandom % 4);
            end else if (nxt != model_rd) begin
                sw_wr = nxt;
                reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = nxt | 24'($urandom % 4);
            end
        end
        last_sel = ($urandom % 2 == 0) ? 2'd2 : 2'd3;
        reg_raddr = last_sel;
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [23:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, input logic [23:0] exp, input string req);
        reg_raddr = sel;
        #1;
        chk(reg_rdata == exp, req, 36'(reg_rdata), 36'(exp));
    endtask

    bit done = 0;

    initial begin
        void'($urandom(32'h1D5E_77A1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int s = 0; s < 4; s++) peek(2'(s), 24'h0, "R1");
        chk(!busy && !mem_req && !cmd_valid, "R1", {33'd0, busy, mem_req, cmd_valid}, 36'd0);

        // R2 aligned writes
        wreg(2'd0, TOP | 24'h3);
        peek(2'd0, TOP, "R2");
        wreg(2'd1, BOT | 24'h2);
        peek(2'd1, BOT, "R2");
        // R3 read write also loads write pointer
        wreg(2'd2, TOP | 24'h1);
        peek(2'd3, TOP, "R3");
        peek(2'd2, TOP, "R3");
        chk(!busy, "R3", 36'(busy), 36'd0);

        // R4 stall while empty
        for (int i = 0; i < 6; i++) step(0, 1);
        chk(!mem_req && !busy, "R4", {34'd0, mem_req, busy}, 36'd0);

        // R4 single word queued: busy rises
        wreg(2'd3, TOP + 24'd4);
        sw_wr = TOP + 24'd4;
        chk(busy, "R4", 36'(busy), 36'd1);
        reg_raddr = 2'd2; last_sel = 2'd2;

        // random traffic
        for (int i = 0; i < 6000; i++) step(1, 1);
        // drain
        for (int i = 0; i < 400 && (model_rd != sw_wr || cmd_valid); i++) step(0, 1);
        repeat (4) step(0, 1);
        chk(model_rd == sw_wr && !busy && !mem_req, "R4", {11'd0, busy, model_rd}, {12'd0, sw_wr});
        chk(n_nat > 0, "R7", 36'(n_nat), 36'd1);
        chk(n_early > 0, "R8", 36'(n_early), 36'd1);
        chk(n_stray > 0, "R8", 36'(n_stray), 36'd1);

        // R3 after traffic, unaligned read pointer write
        wreg(2'd2, 24'h00012B);
        peek(2'd3, 24'h000128, "R3");
        peek(2'd2, 24'h000128, "R3");
        chk(!busy, "R3", 36'(busy), 36'd0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule